// File: doc/BRIEF.md
# Deblocking Edge Filter Mask Decision

This block sits in front of a deblocking filter datapath and decides, for one pixel column crossing a block edge, which of three nested smoothing filters is allowed to touch it. A column carries eight samples on each side of the edge: the near side `p0..p7` and the far side `q0..q7`, with index 0 adjacent to the edge. Samples are 10-bit or 12-bit. Three 8-bit limits come in with the column: an edge limit, an interior limit and a variance limit. A width selection and a depth flag come in as well. For each column the block returns a narrow, medium or wide filter enable, at most one of them set, and a high-variance flag. The downstream filter uses that flag to decide whether to adjust the second sample on each side.

Columns arrive on a valid/ready stream and leave on another, through one register stage. An accepted column shows up on the output one clock later. The input accepts whenever the output stage is empty or is being drained in the same cycle, so `in_ready` follows `out_ready` combinationally. While the output holds a column that the consumer has not taken, the input is stalled and the held result does not change. The limits, width and depth are sampled together with the column that they accompany.

Top module: `edge_mask_dec`

## Requirements
- R1: The edge, interior and variance limits are scaled by a left shift of 2 when `deep`=0 (10-bit) and by 4 when `deep`=1 (12-bit). Every comparison uses the scaled value.
- R2: Filtering is disabled if any neighbour step |p1−p0|, |p2−p1|, |p3−p2|, |q1−q0|, |q2−q1| or |q3−q2| is strictly greater than the scaled interior limit. A step equal to the limit does not disable filtering.
- R3: Filtering is also disabled when 2·|p0−q0| + (|p1−q1| >> 1) is strictly greater than the scaled edge limit.
- R4: `out_hev` is 1 exactly when |p1−p0| or |q1−q0| is strictly greater than the scaled variance limit. It is reported whether or not filtering is enabled.
- R5: A column is flat near the edge when |p1−p0|, |p2−p0|, |p3−p0|, |q1−q0|, |q2−q0| and |q3−q0| are all at most the flatness limit. That limit is 4 when `deep`=0 and 16 when `deep`=1.
- R6: `width_sel` 2 or 3 selects the widest mode. The column is flat far from the edge when |pk−p0| and |qk−q0| are at most the flatness limit for every k from 4 to 7. Wide is set when filtering is enabled and the column is flat both near and far. Medium is set when it is enabled, flat near the edge and not flat far from it. Narrow is set when it is enabled and not flat near the edge.
- R7: `width_sel`=1 (medium mode) sets medium when filtering is enabled and the column is flat near the edge, and sets narrow when it is enabled and not flat near the edge. The far samples have no effect on the result.
- R8: `width_sel`=0 (narrow mode) sets narrow exactly when filtering is enabled. Medium and wide are never set in this mode.
- R9: At most one of `out_f4`, `out_f8` and `out_f16` is set. All three are 0 when filtering is disabled.
- R10: A column accepted on a clock edge (`in_valid` and `in_ready` both 1) is presented with `out_valid`=1 after that edge. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values.
- R11: After reset, `out_valid` and all four flags are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input column present |
| in_ready | output | 1 | Block can accept a column this cycle |
| in_p | input | 8*SW | Near-side samples, pk at bits [k*SW +: SW] |
| in_q | input | 8*SW | Far-side samples, qk at bits [k*SW +: SW] |
| thr_e | input | 8 | Edge limit before scaling |
| thr_i | input | 8 | Interior limit before scaling |
| thr_h | input | 8 | Variance limit before scaling |
| width_sel | input | 2 | 0 narrow, 1 medium, 2 or 3 wide |
| deep | input | 1 | 0 = 10-bit samples, 1 = 12-bit samples |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_f4 | output | 1 | Narrow filter enable |
| out_f8 | output | 1 | Medium filter enable |
| out_f16 | output | 1 | Wide filter enable |
| out_hev | output | 1 | High edge variance flag |

## Verification
Two functions can land in the same cycle. One is a new column arriving while the output stage still holds an unconsumed result. The other is the release of that result. The bench provokes this by stalling the consumer and then offering a second column with different limits and width. It judges that the held flags do not move while stalled. It also judges that the second column is taken on the very edge where `out_ready` rises and appears one clock later. A further case is a column whose limit comparisons fail and whose variance test fires at the same time: the bench checks that the variance flag still comes out with all filter enables cleared.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;
  typedef enum logic [1:0] {
    WID_NARROW = 2'd0,
    WID_MEDIUM = 2'd1,
    WID_WIDE   = 2'd2,
    WID_WIDE_B = 2'd3
  } width_e;

  localparam int LO_SHIFT = 2;
  localparam int HI_SHIFT = 4;
  localparam int LO_FLAT  = 4;
  localparam int HI_FLAT  = 16;
endpackage

// File: rtl/edge_thr_scale.sv
module edge_thr_scale
  import edge_mask_pkg::*;
#(
  parameter int SW = 12,
  parameter int TW = SW + 1
) (
  input  logic [7:0]    thr_e,
  input  logic [7:0]    thr_i,
  input  logic [7:0]    thr_h,
  input  logic          deep,
  output logic [TW-1:0] lim_e,
  output logic [TW-1:0] lim_i,
  output logic [TW-1:0] lim_h,
  output logic [TW-1:0] lim_f
);
  localparam int PADW = TW - 8;

  logic [TW-1:0] ext_e, ext_i, ext_h;

  always_comb begin
    ext_e = {{PADW{1'b0}}, thr_e};
    ext_i = {{PADW{1'b0}}, thr_i};
    ext_h = {{PADW{1'b0}}, thr_h};
    if (deep) begin
      lim_e = ext_e << HI_SHIFT;
      lim_i = ext_i << HI_SHIFT;
      lim_h = ext_h << HI_SHIFT;
      lim_f = TW'(HI_FLAT);
    end else begin
      lim_e = ext_e << LO_SHIFT;
      lim_i = ext_i << LO_SHIFT;
      lim_h = ext_h << LO_SHIFT;
      lim_f = TW'(LO_FLAT);
    end
  end
endmodule

// File: rtl/edge_side_eval.sv
module edge_side_eval #(
  parameter int SW = 12,
  parameter int TW = SW + 1
) (
  input  logic [8*SW-1:0] smp,
  input  logic [TW-1:0]   lim_i,
  input  logic [TW-1:0]   lim_h,
  input  logic [TW-1:0]   lim_f,
  output logic            over_i,
  output logic            hev,
  output logic            rough_in,
  output logic            rough_out
);
  localparam int TAPS  = 8;
  localparam int NEAR  = 4;
  localparam int DW    = SW + 1;
  localparam int NFAR  = TAPS - NEAR;

  function automatic logic [DW-1:0] mag(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic signed [DW-1:0] d;
    d = $signed({1'b0, a}) - $signed({1'b0, b});
    return d[DW-1] ? $unsigned(-d) : $unsigned(d);
  endfunction

  logic [SW-1:0] s [TAPS];
  logic [NFAR-1:0] far_bad;
  logic [DW-1:0] n10, n21, n32, d20, d30;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign s[k] = smp[k*SW +: SW];
  end

  for (genvar k = NEAR; k < TAPS; k++) begin : g_far
    assign far_bad[k-NEAR] = mag(s[k], s[0]) > lim_f;
  end

  always_comb begin
    n10 = mag(s[1], s[0]);
    n21 = mag(s[2], s[1]);
    n32 = mag(s[3], s[2]);
    d20 = mag(s[2], s[0]);
    d30 = mag(s[3], s[0]);
    over_i    = (n10 > lim_i) | (n21 > lim_i) | (n32 > lim_i);
    hev       = n10 > lim_h;
    rough_in  = (n10 > lim_f) | (d20 > lim_f) | (d30 > lim_f);
    rough_out = |far_bad;
  end
endmodule

// File: rtl/edge_cross_eval.sv
module edge_cross_eval #(
  parameter int SW = 12,
  parameter int TW = SW + 1
) (
  input  logic [SW-1:0] p0,
  input  logic [SW-1:0] p1,
  input  logic [SW-1:0] q0,
  input  logic [SW-1:0] q1,
  input  logic [TW-1:0] lim_e,
  output logic          over_e
);
  localparam int DW = SW + 1;
  localparam int XW = SW + 3;

  function automatic logic [DW-1:0] mag(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic signed [DW-1:0] d;
    d = $signed({1'b0, a}) - $signed({1'b0, b});
    return d[DW-1] ? $unsigned(-d) : $unsigned(d);
  endfunction

  logic [DW-1:0] a00, a11;
  logic [XW-1:0] score;

  always_comb begin
    a00    = mag(p0, q0);
    a11    = mag(p1, q1);
    score  = {1'b0, a00, 1'b0} + {3'b000, a11[DW-1:1]};
    over_e = score > {{(XW-TW){1'b0}}, lim_e};
  end
endmodule

// File: rtl/edge_mask_dec.sv
module edge_mask_dec
  import edge_mask_pkg::*;
#(
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [8*SW-1:0] in_p,
  input  logic [8*SW-1:0] in_q,
  input  logic [7:0]    thr_e,
  input  logic [7:0]    thr_i,
  input  logic [7:0]    thr_h,
  input  logic [1:0]    width_sel,
  input  logic          deep,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_f4,
  output logic          out_f8,
  output logic          out_f16,
  output logic          out_hev
);
  localparam int TW    = SW + 1;
  localparam int SIDES = 2;

  logic [TW-1:0] lim_e, lim_i, lim_h, lim_f;
  logic [SIDES-1:0] over_i, hev_s, rough_in, rough_out;
  logic over_e;
  logic enable, flat_in, flat_out;
  logic nx_f4, nx_f8, nx_f16, nx_hev;
  width_e wsel;

  edge_thr_scale #(.SW(SW), .TW(TW)) u_scale (
    .thr_e(thr_e), .thr_i(thr_i), .thr_h(thr_h), .deep(deep),
    .lim_e(lim_e), .lim_i(lim_i), .lim_h(lim_h), .lim_f(lim_f)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    edge_side_eval #(.SW(SW), .TW(TW)) u_side (
      .smp      ((g == 0) ? in_p : in_q),
      .lim_i    (lim_i),
      .lim_h    (lim_h),
      .lim_f    (lim_f),
      .over_i   (over_i[g]),
      .hev      (hev_s[g]),
      .rough_in (rough_in[g]),
      .rough_out(rough_out[g])
    );
  end

  edge_cross_eval #(.SW(SW), .TW(TW)) u_cross (
    .p0(in_p[0 +: SW]), .p1(in_p[SW +: SW]),
    .q0(in_q[0 +: SW]), .q1(in_q[SW +: SW]),
    .lim_e(lim_e), .over_e(over_e)
  );

  always_comb begin
    wsel     = width_e'(width_sel);
    enable   = ~(|over_i) & ~over_e;
    flat_in  = ~(|rough_in);
    flat_out = ~(|rough_out);
    nx_hev   = |hev_s;
    nx_f4    = 1'b0;
    nx_f8    = 1'b0;
    nx_f16   = 1'b0;
    unique case (wsel)
      WID_NARROW: nx_f4 = enable;
      WID_MEDIUM: begin
        nx_f8 = enable & flat_in;
        nx_f4 = enable & ~flat_in;
      end
      default: begin
        nx_f16 = enable & flat_in & flat_out;
        nx_f8  = enable & flat_in & ~flat_out;
        nx_f4  = enable & ~flat_in;
      end
    endcase
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_f4    <= 1'b0;
      out_f8    <= 1'b0;
      out_f16   <= 1'b0;
      out_hev   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_f4    <= nx_f4;
      out_f8    <= nx_f8;
      out_f16   <= nx_f16;
      out_hev   <= nx_hev;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_one_filter: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_f4, out_f8, out_f16}));

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_f4, out_f8, out_f16, out_hev})));

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_narrow_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && width_sel == 2'd0) |=> (!out_f8 && !out_f16));

  a_r7_no_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && width_sel == 2'd1) |=> !out_f16);

  a_r11_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);
endmodule

// File: tb/sim_edge_mask_dec.sv
module sim_edge_mask_dec;
  localparam int SW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [8*SW-1:0] in_p = '0;
  logic [8*SW-1:0] in_q = '0;
  logic [7:0] thr_e = '0, thr_i = '0, thr_h = '0;
  logic [1:0] width_sel = '0;
  logic deep = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_f4, out_f8, out_f16, out_hev;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  int pv [8];
  int qv [8];
  int te, ti, th, ws;
  bit dp;

  edge_mask_dec #(.SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_p(in_p), .in_q(in_q), .thr_e(thr_e), .thr_i(thr_i), .thr_h(thr_h),
    .width_sel(width_sel), .deep(deep), .out_valid(out_valid), .out_ready(out_ready),
    .out_f4(out_f4), .out_f8(out_f8), .out_f16(out_f16), .out_hev(out_hev)
  );

  always #10 clk = ~clk;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Reference from the requirements: returns {hev, f16, f8, f4}
  function automatic logic [3:0] model();
    int sh, le, li, lh, lf;
    bit en, fin, fout, hev;
    logic [3:0] r;
    sh = dp ? 4 : 2;                         // R1
    le = te << sh; li = ti << sh; lh = th << sh;
    lf = dp ? 16 : 4;                        // R5
    en = 1;
    for (int k = 1; k < 4; k++) begin        // R2
      if (iabs(pv[k] - pv[k-1]) > li) en = 0;
      if (iabs(qv[k] - qv[k-1]) > li) en = 0;
    end
    if (2 * iabs(pv[0] - qv[0]) + (iabs(pv[1] - qv[1]) >> 1) > le) en = 0; // R3
    hev = (iabs(pv[1] - pv[0]) > lh) || (iabs(qv[1] - qv[0]) > lh);       // R4
    fin = 1;
    for (int k = 1; k < 4; k++)
      if (iabs(pv[k] - pv[0]) > lf || iabs(qv[k] - qv[0]) > lf) fin = 0;
    fout = 1;
    for (int k = 4; k < 8; k++)              // R6
      if (iabs(pv[k] - pv[0]) > lf || iabs(qv[k] - qv[0]) > lf) fout = 0;
    r = {hev, 3'b000};
    if (ws == 0) r[0] = en;                  // R8
    else if (ws == 1) begin                  // R7
      r[1] = en & fin; r[0] = en & ~fin;
    end else begin
      r[2] = en & fin & fout; r[1] = en & fin & ~fout; r[0] = en & ~fin;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (valid,hev,f16,f8,f4)", req, got, exp);
    end
  endtask

  task automatic set_flat(input int v, input int w, input bit d);
    for (int k = 0; k < 8; k++) begin pv[k] = v; qv[k] = v; end
    te = 10; ti = 5; th = 3; ws = w; dp = d;
  endtask

  task automatic drive();
    for (int k = 0; k < 8; k++) begin
      in_p[k*SW +: SW] = 12'(pv[k]);
      in_q[k*SW +: SW] = 12'(qv[k]);
    end
    thr_e = 8'(te); thr_i = 8'(ti); thr_h = 8'(th);
    width_sel = 2'(ws); deep = dp;
  endtask

  function automatic logic [4:0] outs();
    return {out_valid, out_hev, out_f16, out_f8, out_f4};
  endfunction

  task automatic send_check(input string req);
    logic [3:0] e;
    e = model();
    @(negedge clk);
    drive();
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, outs(), {1'b1, e});
  endtask

  task automatic t_reset();
    check("R11 reset outputs", outs(), 5'b00000);
    check("R11 reset ready", {4'b0000, in_ready}, 5'b00001);
  endtask

  task automatic t_wide();
    set_flat(500, 2, 0);                     // all flat -> wide
    send_check("R6 flat wide");
    set_flat(500, 2, 0); pv[7] = 504;        // far diff equals limit 4
    send_check("R5 R6 far boundary equal");
    set_flat(500, 2, 0); pv[7] = 505;        // far diff 5 -> medium
    send_check("R6 far rough gives medium");
    set_flat(500, 2, 0); qv[3] = 505;        // near diff 5 -> narrow
    send_check("R5 near rough gives narrow");
    set_flat(500, 3, 0); qv[6] = 490;        // code 3 acts as wide
    send_check("R6 code3 wide");
  endtask

  task automatic t_interior();
    set_flat(500, 2, 0); pv[3] = 520;        // step 20 == 5<<2 -> enabled, narrow
    send_check("R2 step equal limit");
    set_flat(500, 2, 0); pv[3] = 521;        // step 21 -> disabled
    send_check("R2 step over limit");
    set_flat(500, 2, 1); pv[3] = 521;        // 12-bit limit 80 -> enabled
    send_check("R1 deep scaling interior");
    set_flat(500, 2, 1); qv[2] = 516;        // deep flat limit 16 -> wide
    send_check("R1 R5 deep flat limit");
  endtask

  task automatic t_edge();
    set_flat(500, 2, 0);
    for (int k = 0; k < 8; k++) qv[k] = 516; // 2*16+8 = 40 == 10<<2
    send_check("R3 edge sum equal limit");
    for (int k = 0; k < 8; k++) qv[k] = 517; // 34+8 = 42 > 40
    send_check("R3 edge sum over limit");
  endtask

  task automatic t_hev();
    set_flat(500, 2, 0); pv[1] = 512;        // 12 == 3<<2, no hev
    send_check("R4 hev equal limit");
    set_flat(500, 2, 0); qv[1] = 513;        // 13 > 12
    send_check("R4 hev over limit");
    set_flat(500, 2, 0); qv[1] = 513; pv[3] = 600; // hev with filtering disabled
    send_check("R4 R9 hev while disabled");
  endtask

  task automatic t_widths();
    set_flat(300, 1, 0); pv[7] = 100;        // far ignored at medium
    send_check("R7 medium ignores far");
    set_flat(300, 1, 0); qv[2] = 290;
    send_check("R7 medium near rough");
    set_flat(300, 0, 0);
    send_check("R8 narrow flat");
    set_flat(300, 0, 0); pv[2] = 330;        // step 30 > 20 -> none
    send_check("R8 narrow disabled");
  endtask

  task automatic t_backpressure();
    logic [3:0] ea, eb;
    set_flat(700, 2, 0); ea = model();       // wide
    @(negedge clk);
    drive(); in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 stalled first", outs(), {1'b1, ea});
    check("R10 ready low when stalled", {4'b0000, in_ready}, 5'b00000);
    set_flat(700, 0, 1); qv[1] = 800; eb = model(); // narrow off, hev set
    drive();
    @(posedge clk);
    @(negedge clk);
    check("R10 held under stall", outs(), {1'b1, ea});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second taken on release", outs(), {1'b1, eb});
    @(posedge clk);
    @(negedge clk);
    check("R10 drained", {out_valid, 4'b0000}, 5'b00000);
  endtask

  task automatic t_stream();
    logic [3:0] e [3];
    @(negedge clk);
    out_ready = 1'b1;
    for (int c = 0; c < 3; c++) begin
      set_flat(200 + 50 * c, c, 0);
      if (c == 2) pv[5] = 190;
      e[c] = model();
      drive(); in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R10 back to back", outs(), {1'b1, e[c]});
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wide();
    t_interior();
    t_edge();
    t_hev();
    t_widths();
    t_backpressure();
    t_stream();
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule